// File: doc/BRIEF.md
# Split-Word Hardware Stack with Flagged Pointer

This block is a small on-chip stack of 15 entries, each 32 bits wide and held as two independent 16-bit halves (high and low). A 6-bit stack pointer tracks it. The lower four bits give the occupied depth and so name the top entry. Two further bits are sticky fault flags: one for any stack fault, one for underflow. A critical-error line to an interrupt controller is raised while either flag is set.

A push moves the pointer up one and then writes the new top row. A pop reads the top row and then moves the pointer down one. Each half carries its own write enable. The top row is always shown on separate high and low read buses. With no push or pop, an asserted half enable rewrites the top row where it stands. The pointer can be loaded directly, which is the only way besides reset to clear the flags. The occupied depth is also decoded into a one-hot row select that is visible at the ports.

Top module: `dual_half_stack`

## Requirements
- R1: After reset the pointer value is 0, critErr is 0, rowSel is 0 and both read buses are 0.
- R2: A push (pushReq=1, popReq=0) when the depth field spValue[3:0] is below 15 raises the depth by one. It then writes wrHiData into the high half if wrHiEn=1 and wrLoData into the low half if wrLoEn=1. A half whose enable is 0 keeps the value that row already held.
- R3: A pop (popReq=1, pushReq=0) when the depth is non-zero lowers the depth by one and changes no stored data. The read buses then show the entry below.
- R4: A push when the depth is 15 sets the fault flag spValue[4]. It leaves the depth at 15 and changes no stored entry.
- R5: A pop when the depth is 0 sets both the underflow flag spValue[5] and the fault flag spValue[4], and the depth stays 0.
- R6: Both flags stay set through any later push, pop or write until a pointer load or reset. critErr equals spValue[4] OR spValue[5].
- R7: spLoad=1 copies spLoadVal into all six pointer bits and takes priority: any push, pop or half write in that cycle is ignored.
- R8: With neither push nor pop, an asserted half enable overwrites that half of the current top row. When the depth is 0 the write is ignored.
- R9: Push and pop together replace the top row in place (enabled halves only) and leave the depth unchanged. When the depth is 0 they act as an underflowing pop and write nothing.
- R10: rowSel is one-hot with bit (depth-1) set, and all zero at depth 0. The read buses carry the row that rowSel selects, or zero at depth 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pushReq | input | 1 | Push strobe |
| popReq | input | 1 | Pop strobe |
| wrHiEn | input | 1 | Write enable for the high half |
| wrLoEn | input | 1 | Write enable for the low half |
| wrHiData | input | 16 | High-half write data |
| wrLoData | input | 16 | Low-half write data |
| spLoad | input | 1 | Load the pointer from spLoadVal |
| spLoadVal | input | 6 | Pointer load value |
| rdHiData | output | 16 | High half of the top entry |
| rdLoData | output | 16 | Low half of the top entry |
| spValue | output | 6 | Pointer: [3:0] depth, [4] fault, [5] underflow |
| rowSel | output | 15 | One-hot decode of the top row |
| critErr | output | 1 | Critical error to the interrupt controller |

## Verification
Push and pop can be requested in the same cycle. Either can also coincide with a pointer load, which must override both. The bench drives these pairs at three points: at a mid depth, at depth 0, and together with spLoad. At mid depth the top row must be replaced with no change in depth. At depth 0 only the flags may change. With spLoad the loaded pointer must win, and a later read must show the stored rows untouched. Every step is judged against a reference model, kept in the bench, of depth, flags and row contents.

// File: rtl/sstack_pkg.sv
package sstack_pkg;
  localparam int Depth = 15;
  localparam int HalfW = 16;
  localparam int PtrW  = $clog2(Depth + 1);
  localparam int SpW   = PtrW + 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic            wrHi;
    logic            wrLo;
    logic [PtrW-1:0] wrPtr;
  } stackStrb_t;
endpackage

// File: rtl/sstack_rowdec.sv
module sstack_rowdec #(
  parameter int ROWS  = sstack_pkg::Depth,
  parameter int PTR_W = sstack_pkg::PtrW
) (
  input  logic [PTR_W-1:0] ptr,
  output logic [ROWS-1:0]  sel
);
  // Depth value n selects row n-1; depth 0 selects nothing
  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign sel[g] = (ptr == PTR_W'(g + 1));
  end
endmodule

// File: rtl/sstack_ctl.sv
module sstack_ctl
  import sstack_pkg::*;
#(
  parameter int DEPTH = sstack_pkg::Depth
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushReq,
  input  logic             popReq,
  input  logic             wrHiReq,
  input  logic             wrLoReq,
  input  logic             spLoad,
  input  logic [SpW-1:0]   spLoadVal,
  output logic [SpW-1:0]   sp,
  output stackStrb_t       strb
);
  localparam int ErrBit = PtrW;
  localparam int UndBit = PtrW + 1;
  localparam logic [PtrW-1:0] FullPtr = PtrW'(DEPTH);

  logic [PtrW-1:0] ptr, nextPtr;
  logic            nextErr, nextUnd;
  logic            isFull, isEmpty;

  assign ptr     = sp[PtrW-1:0];
  assign isFull  = (ptr == FullPtr);
  assign isEmpty = (ptr == '0);

  always_comb begin
    nextPtr = ptr;
    nextErr = sp[ErrBit];
    nextUnd = sp[UndBit];
    strb    = '0;
    if (spLoad) begin
      {nextUnd, nextErr, nextPtr} = spLoadVal;
    end else begin
      unique case ({pushReq, popReq})
        2'b10: begin
          if (isFull) begin
            nextErr = 1'b1;
          end else begin
            nextPtr    = ptr + 1'b1;
            strb.wrHi  = wrHiReq;
            strb.wrLo  = wrLoReq;
            strb.wrPtr = ptr + 1'b1;
          end
        end
        2'b01: begin
          if (isEmpty) begin
            nextErr = 1'b1;
            nextUnd = 1'b1;
          end else begin
            nextPtr = ptr - 1'b1;
          end
        end
        2'b11: begin
          if (isEmpty) begin
            nextErr = 1'b1;
            nextUnd = 1'b1;
          end else begin
            strb.wrHi  = wrHiReq;
            strb.wrLo  = wrLoReq;
            strb.wrPtr = ptr;
          end
        end
        default: begin
          if (!isEmpty) begin
            strb.wrHi  = wrHiReq;
            strb.wrLo  = wrLoReq;
            strb.wrPtr = ptr;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sp <= '0;
    else       sp <= {nextUnd, nextErr, nextPtr};
  end

  // R2
  push_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !popReq && !spLoad && !isFull) |=> (sp[PtrW-1:0] == $past(ptr) + 1'b1));
  // R4
  push_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !popReq && !spLoad && isFull) |=> (sp[ErrBit] && sp[PtrW-1:0] == FullPtr));
  // R5
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !spLoad && isEmpty) |=> (sp[ErrBit] && sp[UndBit] && sp[PtrW-1:0] == '0));
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sp[ErrBit] && !spLoad) |=> sp[ErrBit]);
  // R6
  und_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sp[UndBit] && !spLoad) |=> sp[UndBit]);
  // R7
  sp_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    spLoad |=> (sp == $past(spLoadVal)));
endmodule

// File: rtl/sstack_dp.sv
module sstack_dp
  import sstack_pkg::*;
#(
  parameter int DEPTH  = sstack_pkg::Depth,
  parameter int HALF_W = sstack_pkg::HalfW
) (
  input  logic              clk,
  input  logic              rstN,
  input  stackStrb_t        strb,
  input  logic [PtrW-1:0]   topPtr,
  input  logic [HALF_W-1:0] hiIn,
  input  logic [HALF_W-1:0] loIn,
  output logic [HALF_W-1:0] hiOut,
  output logic [HALF_W-1:0] loOut,
  output logic [DEPTH-1:0]  rdSel
);
  logic [DEPTH-1:0]  wrSel;
  logic [HALF_W-1:0] hiMem [DEPTH];
  logic [HALF_W-1:0] loMem [DEPTH];

  sstack_rowdec #(.ROWS(DEPTH), .PTR_W(PtrW)) i_rdDec (.ptr(topPtr),     .sel(rdSel));
  sstack_rowdec #(.ROWS(DEPTH), .PTR_W(PtrW)) i_wrDec (.ptr(strb.wrPtr), .sel(wrSel));

  for (genvar r = 0; r < DEPTH; r++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hiMem[r] <= '0;
        loMem[r] <= '0;
      end else begin
        if (strb.wrHi && wrSel[r]) hiMem[r] <= hiIn;
        if (strb.wrLo && wrSel[r]) loMem[r] <= loIn;
      end
    end
  end

  always_comb begin
    hiOut = '0;
    loOut = '0;
    for (int r = 0; r < DEPTH; r++) begin
      if (rdSel[r]) begin
        hiOut = hiOut | hiMem[r];
        loOut = loOut | loMem[r];
      end
    end
  end

  // R10
  rowsel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(rdSel));
  // R2
  hi_written_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrHi |=> (hiOut == $past(hiIn)));
  // R8
  lo_written_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLo |=> (loOut == $past(loIn)));
endmodule

// File: rtl/dual_half_stack.sv
module dual_half_stack
  import sstack_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushReq,
  input  logic             popReq,
  input  logic             wrHiEn,
  input  logic             wrLoEn,
  input  logic [HalfW-1:0] wrHiData,
  input  logic [HalfW-1:0] wrLoData,
  input  logic             spLoad,
  input  logic [SpW-1:0]   spLoadVal,
  output logic [HalfW-1:0] rdHiData,
  output logic [HalfW-1:0] rdLoData,
  output logic [SpW-1:0]   spValue,
  output logic [Depth-1:0] rowSel,
  output logic             critErr
);
  stackStrb_t strb;

  sstack_ctl #(.DEPTH(Depth)) i_ctl (
    .clk, .rstN, .pushReq, .popReq,
    .wrHiReq(wrHiEn), .wrLoReq(wrLoEn),
    .spLoad, .spLoadVal,
    .sp(spValue), .strb
  );

  sstack_dp #(.DEPTH(Depth), .HALF_W(HalfW)) i_dp (
    .clk, .rstN, .strb,
    .topPtr(spValue[PtrW-1:0]),
    .hiIn(wrHiData), .loIn(wrLoData),
    .hiOut(rdHiData), .loOut(rdLoData),
    .rdSel(rowSel)
  );

  assign critErr = spValue[PtrW] | spValue[PtrW+1];

  // R6
  crit_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    critErr == (spValue[SpW-1:SpW-2] != 2'b00));
endmodule

// File: tb/test_dual_half_stack.sv
module test_dual_half_stack;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushReq = 0, popReq = 0, wrHiEn = 0, wrLoEn = 0, spLoad = 0;
  logic [15:0] wrHiData = '0, wrLoData = '0;
  logic [5:0]  spLoadVal = '0;
  logic [15:0] rdHiData, rdLoData;
  logic [5:0]  spValue;
  logic [14:0] rowSel;
  logic        critErr;

  int checks = 0;
  int errors = 0;

  // reference model
  logic [15:0] mHi [1:15];
  logic [15:0] mLo [1:15];
  int   mPtr = 0;
  logic mErr = 0, mUnd = 0;

  always #10 clk = ~clk;

  dual_half_stack i_dual_half_stack (
    .clk, .rstN, .pushReq, .popReq, .wrHiEn, .wrLoEn, .wrHiData, .wrLoData,
    .spLoad, .spLoadVal, .rdHiData, .rdLoData, .spValue, .rowSel, .critErr
  );

  task automatic checkAll(input string tag);
    logic [15:0] eHi, eLo;
    logic [14:0] eSel;
    logic [5:0]  eSp;
    eHi  = (mPtr == 0) ? 16'h0 : mHi[mPtr];
    eLo  = (mPtr == 0) ? 16'h0 : mLo[mPtr];
    eSel = (mPtr == 0) ? 15'h0 : (15'h1 << (mPtr - 1));
    eSp  = {mUnd, mErr, 4'(mPtr)};
    checks++;
    if (rdHiData !== eHi || rdLoData !== eLo || rowSel !== eSel ||
        spValue !== eSp || critErr !== (mErr | mUnd)) begin
      errors++;
      $display("FAIL %s: hi=%h lo=%h sel=%h sp=%h crit=%b expected hi=%h lo=%h sel=%h sp=%h crit=%b",
               tag, rdHiData, rdLoData, rowSel, spValue, critErr,
               eHi, eLo, eSel, eSp, mErr | mUnd);
    end
  endtask

  task automatic step(input logic push, input logic pop, input logic wh, input logic wl,
                      input logic [15:0] h, input logic [15:0] l,
                      input logic ld, input logic [5:0] ldv, input string tag);
    @(negedge clk);
    pushReq = push; popReq = pop; wrHiEn = wh; wrLoEn = wl;
    wrHiData = h; wrLoData = l; spLoad = ld; spLoadVal = ldv;
    @(negedge clk);
    pushReq = 0; popReq = 0; wrHiEn = 0; wrLoEn = 0; spLoad = 0;
    if (ld) begin
      mPtr = int'(ldv[3:0]); mErr = ldv[4]; mUnd = ldv[5];
    end else if (push && !pop) begin
      if (mPtr == 15) mErr = 1;
      else begin
        mPtr++;
        if (wh) mHi[mPtr] = h;
        if (wl) mLo[mPtr] = l;
      end
    end else if (pop && mPtr == 0) begin
      mErr = 1; mUnd = 1;
    end else if (pop && !push) begin
      mPtr--;
    end else if (mPtr != 0) begin
      if (wh) mHi[mPtr] = h;
      if (wl) mLo[mPtr] = l;
    end
    checkAll(tag);
  endtask

  task automatic tReset();
    for (int i = 1; i <= 15; i++) begin mHi[i] = '0; mLo[i] = '0; end
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkAll("R1 reset state");
  endtask

  task automatic tPushPop();
    step(1, 0, 1, 1, 16'hA1A1, 16'hB1B1, 0, 0, "R2 push both halves");
    step(1, 0, 1, 0, 16'hC2C2, 16'hDEAD, 0, 0, "R2 push high only");
    step(1, 0, 0, 1, 16'hBEEF, 16'hE3E3, 0, 0, "R2 push low only");
    step(0, 1, 0, 0, 0, 0, 0, 0, "R3 pop to depth 2");
    step(0, 1, 1, 1, 16'h1111, 16'h2222, 0, 0, "R3 pop ignores data");
  endtask

  task automatic tOverflow();
    while (mPtr < 15)
      step(1, 0, 1, 1, 16'(mPtr * 257), 16'(~(mPtr * 31)), 0, 0, "R2 fill");
    step(1, 0, 1, 1, 16'h5555, 16'h6666, 0, 0, "R4 push when full");
    step(1, 0, 1, 1, 16'h7777, 16'h8888, 0, 0, "R4 second push when full");
    step(0, 1, 0, 0, 0, 0, 0, 0, "R6 fault flag sticky over pop");
  endtask

  task automatic tLoad();
    step(0, 0, 0, 0, 0, 0, 1, 6'h0E, "R7 load clears flags");
    step(1, 1, 1, 1, 16'h9999, 16'h9999, 1, 6'h03, "R7 load beats push and pop");
    step(0, 0, 0, 0, 0, 0, 1, 6'h04, "R7 rows untouched by overridden ops");
  endtask

  task automatic tInPlace();
    step(0, 0, 1, 0, 16'h4242, 16'h0000, 0, 0, "R8 in-place high write");
    step(0, 0, 0, 1, 16'hFFFF, 16'h4343, 0, 0, "R8 in-place low write");
    step(1, 1, 1, 1, 16'hAAAA, 16'hBBBB, 0, 0, "R9 push and pop replace top");
    step(1, 1, 0, 1, 16'hCCCC, 16'hDDDD, 0, 0, "R9 push and pop low half only");
  endtask

  task automatic tEmpty();
    step(0, 0, 0, 0, 0, 0, 1, 6'h00, "R7 load depth 0");
    step(0, 0, 1, 1, 16'h1234, 16'h5678, 0, 0, "R8 write ignored at depth 0");
    step(1, 1, 1, 1, 16'h1357, 16'h2468, 0, 0, "R9 push and pop at depth 0 underflow");
    step(0, 0, 0, 0, 0, 0, 1, 6'h00, "R7 clear flags");
    step(0, 1, 0, 0, 0, 0, 0, 0, "R5 pop when empty");
    step(1, 0, 0, 0, 16'hFFFF, 16'hFFFF, 0, 0, "R8 row 1 unchanged, R6 flags sticky over push");
    step(1, 0, 1, 1, 16'h0F0F, 16'hF0F0, 0, 0, "R10 row select depth 2");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tReset();
    tPushPop();
    tOverflow();
    tLoad();
    tInPlace();
    tEmpty();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule